// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual-Loop Synthesizer

This block receives configuration words over a three-wire serial link: a serial clock, a data line and an enable line. It decodes each word into the registers that set up a radio synthesizer and the functions next to it. Data is captured most significant bit first on each rising edge of the serial clock. A frame ends when the enable line changes level. At that moment the captured bits are written to their destination, or thrown away if the frame is not well formed.

While enable is low, each word is 16 bits long. Its top two bits choose the destination: the control register, the receive divider, the reference divider or the transmit divider. While enable is high, one other register is loaded. This register holds six oscillator capacitor trim bits and a four-bit battery threshold code. The frame for it is either 12 or 16 bits long, and the padding after its leading marker bit is ignored. The block also decodes the battery code into a small threshold index for the comparator that uses it.

All serial inputs are treated as synchronous to `clk`. Any synchronizing stage belongs to the surrounding design.

Top module: `prog_shift_if`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_dat` into the frame, most significant bit first. A frame ends when `ser_en` changes level, and its effect is visible at the outputs within two `clk` cycles of that change.
- R2: A frame sent with enable low is routed by bits 15:14 of the last 16 bits shifted. The code 00 selects control, 01 the receive divider, 10 the reference divider and 11 the transmit divider. A frame sent with enable high never changes any divider or control output.
- R3: In a reference word, bits 13:12 go to `ref_region` and bits 11:0 go to `ref_div`.
- R4: In a receive or transmit word, bits 13:0 go to `rx_div` or `tx_div` respectively.
- R5: In a control word, bit 12 goes to `tx_pll_off`, 11 to `comp_mute`, 10 to `comp_off`, 9 to `exp_mute`, 8 to `exp_off`, 7 to `lock_sel`, 6 to `batt_off`, 5 to `rx_off`, and bits 1:0 to `test_bits`.
- R6: A frame sent with enable high loads the trim/battery register when it is 12 bits long with bit 11 set, or 16 bits long with bit 15 set. Bits 9:6 go to `batt_code` and bits 5:0 go to `cap_sel`. A frame sent with enable low never changes these outputs.
- R7: A frame sent with enable high is discarded when its leading bit is 0 or its length is anything other than 12 or 16.
- R8: `batt_idx` decodes `batt_code` as follows: 0000 gives 0 (3.45 V), 1011 gives 1 (3.3 V), 1101 gives 2 (3.0 V), 0111 gives 3 (2.2 V) and 1111 gives 4 (2.1 V). Every other code gives 0.
- R9: Frames shorter than 12 bits, and enable-low frames of 12 to 15 bits, change no register. An enable-low frame longer than 16 bits uses its last 16 bits.
- R10: Reset (`rst_n` low) sets `rx_div` to 7215, `tx_div` to 9966 and `ref_div` to 2048. It clears `ref_region`, all control outputs, `cap_sel` and `batt_code`.
- R11: No output register changes except on the `clk` cycle that follows a change of `ser_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Frame enable; its level selects the register bank |
| tx_div | output | 14 | Transmit divider ratio |
| rx_div | output | 14 | Receive divider ratio |
| ref_div | output | 12 | Reference divider ratio |
| ref_region | output | 2 | Regional reference-rate select |
| tx_pll_off | output | 1 | Transmit loop power-down |
| comp_mute | output | 1 | Compressor mute |
| comp_off | output | 1 | Compressor power-down |
| exp_mute | output | 1 | Expander mute |
| exp_off | output | 1 | Expander power-down |
| lock_sel | output | 1 | Shared pin shows lock (1) or carrier detect (0) |
| batt_off | output | 1 | Battery detector power-down |
| rx_off | output | 1 | Receive path power-down |
| test_bits | output | 2 | Test mode selection |
| cap_sel | output | 6 | Oscillator capacitor trim selects |
| batt_code | output | 4 | Raw battery threshold code |
| batt_idx | output | 3 | Decoded battery threshold index |

## Verification
A corrupted shift register or bit counter shows up at the very next enable transition. The wrong destination is written, the wrong field value lands, or a valid frame is dropped. This is visible on the outputs within two `clk` cycles of that transition. A stuck enable-level register shows up as a frame routed to the wrong bank: dividers change after an enable-high frame, or trims change after an enable-low word. Each frame ends with a compare of all outputs against a bench model, so such errors are caught on the frame where they first occur.

// File: rtl/prog_shift_if.sv
module prog_shift_if #(
  parameter logic [13:0] TX_RST  = 14'd9966,
  parameter logic [13:0] RX_RST  = 14'd7215,
  parameter logic [11:0] REF_RST = 12'd2048,
  parameter int          CNT_W   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_en,
  output logic [13:0] tx_div,
  output logic [13:0] rx_div,
  output logic [11:0] ref_div,
  output logic [1:0]  ref_region,
  output logic        tx_pll_off,
  output logic        comp_mute,
  output logic        comp_off,
  output logic        exp_mute,
  output logic        exp_off,
  output logic        lock_sel,
  output logic        batt_off,
  output logic        rx_off,
  output logic [1:0]  test_bits,
  output logic [5:0]  cap_sel,
  output logic [3:0]  batt_code,
  output logic [2:0]  batt_idx
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(12);
  localparam logic [CNT_W-1:0] LEN_L   = CNT_W'(16);

  logic             sclk_q, en_q;
  logic [15:0]      sr;
  logic [CNT_W-1:0] cnt;
  logic [9:0]       ctrl_q;

  wire sclk_rise = ser_clk & ~sclk_q;
  wire en_edge   = ser_en ^ en_q;
  wire lo_ok     = en_edge & ~en_q & (cnt >= LEN_L);
  wire hi_ok     = en_edge & en_q &
                   (((cnt == LEN_S) & sr[11]) | ((cnt == LEN_L) & sr[15]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= ser_clk;
      en_q   <= ser_en;
      if (en_edge) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sr <= {sr[14:0], ser_dat};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_div     <= TX_RST;
      rx_div     <= RX_RST;
      ref_div    <= REF_RST;
      ref_region <= '0;
      ctrl_q     <= '0;
      cap_sel    <= '0;
      batt_code  <= '0;
    end else if (lo_ok) begin
      unique case (sr[15:14])
        2'b00: ctrl_q <= {sr[12:5], sr[1:0]};
        2'b01: rx_div <= sr[13:0];
        2'b10: begin
          ref_region <= sr[13:12];
          ref_div    <= sr[11:0];
        end
        default: tx_div <= sr[13:0];
      endcase
    end else if (hi_ok) begin
      batt_code <= sr[9:6];
      cap_sel   <= sr[5:0];
    end
  end

  assign {tx_pll_off, comp_mute, comp_off, exp_mute, exp_off,
          lock_sel, batt_off, rx_off, test_bits} = ctrl_q;

  always_comb begin
    case (batt_code)
      4'b1011: batt_idx = 3'd1;
      4'b1101: batt_idx = 3'd2;
      4'b0111: batt_idx = 3'd3;
      4'b1111: batt_idx = 3'd4;
      default: batt_idx = 3'd0;
    endcase
  end

endmodule

// File: rtl/prog_shift_if_chk.sv
module prog_shift_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_en,
  input logic        en_q,
  input logic [13:0] tx_div,
  input logic [13:0] rx_div,
  input logic [11:0] ref_div,
  input logic [1:0]  ref_region,
  input logic [9:0]  ctrl_q,
  input logic [5:0]  cap_sel,
  input logic [3:0]  batt_code,
  input logic [2:0]  batt_idx
);

  p_hold_no_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en == en_q) |=> ($stable(tx_div) && $stable(rx_div) && $stable(ref_div) &&
                          $stable(ref_region) && $stable(ctrl_q) &&
                          $stable(cap_sel) && $stable(batt_code)));

  p_hi_frame_no_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !ser_en) |=> ($stable(tx_div) && $stable(rx_div) && $stable(ref_div) &&
                           $stable(ref_region) && $stable(ctrl_q)));

  p_lo_frame_no_trim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && ser_en) |=> ($stable(cap_sel) && $stable(batt_code)));

  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    batt_idx <= 3'd4);

  p_idx_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_code == 4'b1111) |-> (batt_idx == 3'd4));

endmodule

bind prog_shift_if prog_shift_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .en_q(en_q),
  .tx_div(tx_div), .rx_div(rx_div), .ref_div(ref_div), .ref_region(ref_region),
  .ctrl_q(ctrl_q), .cap_sel(cap_sel), .batt_code(batt_code), .batt_idx(batt_idx)
);

// File: tb/prog_shift_if_tb.sv
module prog_shift_if_tb;
  logic clk = 1'b0, rst_n = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1;
  logic [13:0] tx_div, rx_div;
  logic [11:0] ref_div;
  logic [1:0]  ref_region, test_bits;
  logic tx_pll_off, comp_mute, comp_off, exp_mute, exp_off, lock_sel, batt_off, rx_off;
  logic [5:0] cap_sel;
  logic [3:0] batt_code;
  logic [2:0] batt_idx;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  prog_shift_if u_dut (.*);

  // {level, length, data[23:0]}
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 5'd16, 24'h0044D2},  // R2 R4 rx=1234
    {1'b0, 5'd16, 24'h00FFFF},  // R2 R4 tx=16383
    {1'b0, 5'd16, 24'h00BFFF},  // R3 region 3, ratio 4095
    {1'b0, 5'd16, 24'h009010},  // R3 region 1, ratio 16
    {1'b0, 5'd16, 24'h001FE3},  // R5 all control bits set
    {1'b0, 5'd16, 24'h000A42},  // R5 sparse control bits
    {1'b1, 5'd12, 24'h000BDC},  // R6 12-bit, code 1111
    {1'b1, 5'd16, 24'h00DAEA},  // R6 16-bit, code 1011
    {1'b1, 5'd12, 24'h0003FF},  // R7 leading 0: discard
    {1'b1, 5'd14, 24'h003FFF},  // R7 14 bits: discard
    {1'b0, 5'd8,  24'h0000FF},  // R9 short: discard
    {1'b0, 5'd14, 24'h000123},  // R9 14-bit low frame: discard
    {1'b0, 5'd20, 24'h0A4005},  // R9 last 16 bits: rx=5
    {1'b1, 5'd12, 24'h000B41},  // R8 code 1101
    {1'b1, 5'd16, 24'h0081C0},  // R8 code 0111
    {1'b1, 5'd12, 24'h00097F},  // R8 code 0101 -> 0
    {1'b1, 5'd12, 24'h000800}   // R8 code 0000
  };

  logic [13:0] m_tx, m_rx;
  logic [11:0] m_ref;
  logic [1:0]  m_reg;
  logic [9:0]  m_ctrl;
  logic [5:0]  m_cap;
  logic [3:0]  m_code;

  function automatic logic [2:0] idx_of(input logic [3:0] c);
    case (c)
      4'b1011: return 3'd1;
      4'b1101: return 3'd2;
      4'b0111: return 3'd3;
      4'b1111: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tx = 14'd9966; m_rx = 14'd7215; m_ref = 12'd2048; m_reg = 0;
    m_ctrl = 0; m_cap = 0; m_code = 0;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R4 tx"}, 32'(tx_div), 32'(m_tx));
    chk({tag, " R4 rx"}, 32'(rx_div), 32'(m_rx));
    chk({tag, " R3 ref"}, 32'({ref_region, ref_div}), 32'({m_reg, m_ref}));
    chk({tag, " R5 ctrl"}, 32'({tx_pll_off, comp_mute, comp_off, exp_mute, exp_off,
                                lock_sel, batt_off, rx_off, test_bits}), 32'(m_ctrl));
    chk({tag, " R6 trim"}, 32'({batt_code, cap_sel}), 32'({m_code, m_cap}));
    chk({tag, " R8 idx"}, 32'(batt_idx), 32'(idx_of(m_code)));
  endtask

  task automatic shift_bits(input logic lvl, input int n, input logic [23:0] d);
    @(negedge clk) ser_en = lvl;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = d[i];
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
      ser_clk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic end_frame(input logic lvl);
    ser_en = ~lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic model_frame(input logic lvl, input int n, input logic [23:0] d);
    logic lead;
    if (!lvl) begin
      if (n >= 16) begin  // R2 routing, R9 length rule
        case (d[15:14])
          2'b00: m_ctrl = {d[12:5], d[1:0]};
          2'b01: m_rx = d[13:0];
          2'b10: begin m_reg = d[13:12]; m_ref = d[11:0]; end
          default: m_tx = d[13:0];
        endcase
      end
    end else begin
      lead = (n == 12) ? d[11] : (n == 16) ? d[15] : 1'b0;  // R6, R7
      if (lead) begin m_code = d[9:6]; m_cap = d[5:0]; end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R10 reset");

    for (int v = 0; v < NV; v++) begin
      shift_bits(VEC[v][29], int'(VEC[v][28:24]), VEC[v][23:0]);
      end_frame(VEC[v][29]);
      model_frame(VEC[v][29], int'(VEC[v][28:24]), VEC[v][23:0]);
      check_all($sformatf("R1 vec%0d", v));
    end

    // R11: complete word shifted but enable not yet toggled
    shift_bits(1'b0, 16, 24'h004007);
    repeat (5) @(negedge clk);
    check_all("R11 pending");
    end_frame(1'b0);
    model_frame(1'b0, 16, 24'h004007);
    check_all("R11 latched");

    // R10: reset after activity restores defaults
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R10 re-reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule